// File: doc/BRIEF.md
# Conditional Render Gate

The block decides whether later draw commands may run. Software writes a mode selector together with a record base address. Two modes fix the answer at once: forced off and forced on. Three modes first fetch a four-word compare record from memory and then derive the answer from it. The record holds a start sequence, a start tag, a live sequence and a live tag. Any selector value outside the five defined modes counts as forced on.

Each outcome is latched in `exec_en` and announced by a one-cycle `eval_done` pulse. The record is fetched one word at a time over a plain request/response read port, with at most one read in flight. A mode write that arrives while an evaluation is running is parked in a one-deep slot and evaluated afterwards. A newer parked write replaces an older one that has not yet started.

Top module: `render_gate`

## Requirements
- R1: During and right after reset, `exec_en` is 1 and `busy`, `eval_done` and `rd_req_valid` are 0.
- R2: Selector 0 (forced off) latches `exec_en`=0 and selector 1 (forced on) latches `exec_en`=1. Both pulse `eval_done` and issue no read request.
- R3: Selector 2 latches 1 when both the start sequence (word 0) and the start tag (word 1) are nonzero, and 0 otherwise.
- R4: Selector 3 latches 1 when word 0 equals word 2 and word 1 equals word 3, and 0 otherwise.
- R5: Selector 4 latches 1 when word 0 differs from word 2 or word 1 differs from word 3, and 0 otherwise.
- R6: Selectors 5, 6 and 7 latch `exec_en`=1 with no read request.
- R7: A fetching mode reads words 0 to 3 in order at base, base+4, base+8 and base+12, one request at a time. A request that is not accepted keeps its address stable until `rd_req_ready`.
- R8: `busy` is high from the acceptance of a fetching mode until its result is latched, and read requests are raised only while `busy` is high.
- R9: A mode write made while `busy` is high is evaluated after the current evaluation ends. Of several such writes, only the last one is evaluated.
- R10: `exec_en` changes only in a cycle in which `eval_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_sel | input | 3 | Mode selector value |
| rec_base | input | ADDR_W | Byte address of the compare record |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Read byte address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 32 | Read data word |
| exec_en | output | 1 | Latched execute-enable |
| busy | output | 1 | Record fetch in progress |
| eval_done | output | 1 | One-cycle pulse when a result is latched |

## Verification
The assertions take for granted that the memory side returns exactly one `rd_rsp_valid` pulse per accepted request, never before the request is accepted, and that reset is held for at least one clock edge. The bench memory model answers only requests it has accepted, with one response each. It varies both the acceptance stall and the response delay. It serves the record words from a table that the driver fills before each fetching write, so every response is well defined.

// File: rtl/rg_pkg.sv
// Package: shared constants, mode codes and record type for the render gate.
// Assumes 32-bit record words, byte addressing and four words per record.
package rg_pkg;
    localparam int RG_WORD_W    = 32;
    localparam int RG_REC_WORDS = 4;
    localparam int RG_MODE_W    = 3;
    localparam int RG_STRIDE    = RG_WORD_W / 8;

    // Word positions inside the fetched record (fetch order)
    localparam int RG_IDX_INIT_SEQ = 0;
    localparam int RG_IDX_INIT_TAG = 1;
    localparam int RG_IDX_CUR_SEQ  = 2;
    localparam int RG_IDX_CUR_TAG  = 3;

    typedef enum logic [RG_MODE_W-1:0] {
        RG_FORCE_OFF = 3'd0,
        RG_FORCE_ON  = 3'd1,
        RG_NONZERO   = 3'd2,
        RG_SAME      = 3'd3,
        RG_CHANGED   = 3'd4
    } rg_mode_e;

    typedef logic [RG_REC_WORDS-1:0][RG_WORD_W-1:0] rg_rec_t;

    // True for the modes that need the record from memory
    function automatic logic rg_needs_fetch(input logic [RG_MODE_W-1:0] m);
        return (m == RG_NONZERO) || (m == RG_SAME) || (m == RG_CHANGED);
    endfunction
endpackage

// File: rtl/rg_hold.sv
// Module: one-deep slot for mode writes.
// A new write always overwrites the slot (latest wins); 'take' empties it
// unless a write lands in the same cycle. Assumes the consumer samples the
// slot contents in the cycle it asserts 'take'.
module rg_hold
    import rg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [RG_MODE_W-1:0] wr_mode,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic                 take,
    output logic                 valid,
    output logic [RG_MODE_W-1:0] mode,
    output logic [ADDR_W-1:0]    addr
);
    // Slot register: load on write, clear on take
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            mode  <= '0;
            addr  <= '0;
        end else if (wr) begin
            valid <= 1'b1;
            mode  <= wr_mode;
            addr  <= wr_addr;
        end else if (take) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/rg_fetch.sv
// Module: sequential record reader.
// Issues RG_REC_WORDS reads, one outstanding at a time, at consecutive word
// addresses from the start address. Assumes one response per accepted request.
// 'rec' shows the stored words with the word arriving this cycle bypassed in,
// so it is complete in the cycle 'rec_done' is high.
module rg_fetch
    import rg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ADDR_W-1:0]    start_addr,
    output logic                 req_valid,
    input  logic                 req_ready,
    output logic [ADDR_W-1:0]    req_addr,
    input  logic                 rsp_valid,
    input  logic [RG_WORD_W-1:0] rsp_data,
    output logic                 busy,
    output logic                 rec_done,
    output rg_rec_t              rec
);
    localparam int IDX_W = $clog2(RG_REC_WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RG_REC_WORDS - 1);

    typedef enum logic [1:0] {F_IDLE, F_ASK, F_WAIT} fstate_e;

    fstate_e          state;
    logic [IDX_W-1:0] idx;
    logic [ADDR_W-1:0] base;
    rg_rec_t          store;
    logic             rsp_take;

    assign rsp_take  = (state == F_WAIT) && rsp_valid;
    assign req_valid = (state == F_ASK);
    assign req_addr  = base + ADDR_W'(idx) * ADDR_W'(RG_STRIDE);
    assign busy      = (state != F_IDLE);
    assign rec_done  = rsp_take && (idx == LAST_IDX);

    // Record view with the arriving word bypassed into its slot
    for (genvar g = 0; g < RG_REC_WORDS; g++) begin : g_view
        assign rec[g] = (rsp_take && idx == IDX_W'(g)) ? rsp_data : store[g];
    end

    // Sequencer: ask, wait for data, advance index or finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= F_IDLE;
            idx   <= '0;
            base  <= '0;
        end else begin
            case (state)
                F_IDLE: if (start) begin
                    state <= F_ASK;
                    idx   <= '0;
                    base  <= start_addr;
                end
                F_ASK: if (req_ready) state <= F_WAIT;
                F_WAIT: if (rsp_valid) begin
                    if (idx == LAST_IDX) begin
                        state <= F_IDLE;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= F_ASK;
                    end
                end
                default: state <= F_IDLE;
            endcase
        end
    end

    // Word storage: capture each arriving word at its index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store <= '0;
        end else if (rsp_take) begin
            store[idx] <= rsp_data;
        end
    end
endmodule

// File: rtl/rg_decide.sv
// Module: combinational enable decision from a mode and a compare record.
// Assumes 'rec' is complete whenever a fetching mode is presented.
module rg_decide
    import rg_pkg::*;
(
    input  logic [RG_MODE_W-1:0] mode,
    input  rg_rec_t              rec,
    output logic                 en
);
    logic seq_eq, tag_eq, start_nz;

    assign seq_eq   = (rec[RG_IDX_INIT_SEQ] == rec[RG_IDX_CUR_SEQ]);
    assign tag_eq   = (rec[RG_IDX_INIT_TAG] == rec[RG_IDX_CUR_TAG]);
    assign start_nz = (rec[RG_IDX_INIT_SEQ] != '0) && (rec[RG_IDX_INIT_TAG] != '0);

    // Mode table; undefined codes fall back to enabled
    always_comb begin
        case (mode)
            RG_FORCE_OFF: en = 1'b0;
            RG_FORCE_ON:  en = 1'b1;
            RG_NONZERO:   en = start_nz;
            RG_SAME:      en = seq_eq && tag_eq;
            RG_CHANGED:   en = !seq_eq || !tag_eq;
            default:      en = 1'b1;
        endcase
    end
endmodule

// File: rtl/render_gate.sv
// Module: conditional render gate top.
// Accepts mode writes into a hold slot, resolves constant modes in one
// cycle and fetches the compare record for the others. It latches the result
// in exec_en with a one-cycle eval_done pulse. Assumes a well-behaved read
// port (one response per accepted request).
module render_gate
    import rg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_wr,
    input  logic [RG_MODE_W-1:0] mode_sel,
    input  logic [ADDR_W-1:0]    rec_base,
    output logic                 rd_req_valid,
    input  logic                 rd_req_ready,
    output logic [ADDR_W-1:0]    rd_req_addr,
    input  logic                 rd_rsp_valid,
    input  logic [RG_WORD_W-1:0] rd_rsp_data,
    output logic                 exec_en,
    output logic                 busy,
    output logic                 eval_done
);
    logic                 slot_valid;
    logic [RG_MODE_W-1:0] slot_mode;
    logic [ADDR_W-1:0]    slot_addr;
    logic                 take, take_mem, take_const;
    logic                 fetch_busy, rec_done;
    rg_rec_t              rec;
    logic [RG_MODE_W-1:0] cur_mode;
    logic [RG_MODE_W-1:0] dec_mode;
    logic                 dec_en;

    assign take       = slot_valid && !fetch_busy;
    assign take_mem   = take && rg_needs_fetch(slot_mode);
    assign take_const = take && !rg_needs_fetch(slot_mode);
    assign dec_mode   = rec_done ? cur_mode : slot_mode;
    assign busy       = fetch_busy;

    rg_hold #(.ADDR_W(ADDR_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (mode_wr),
        .wr_mode (mode_sel),
        .wr_addr (rec_base),
        .take    (take),
        .valid   (slot_valid),
        .mode    (slot_mode),
        .addr    (slot_addr)
    );

    rg_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (take_mem),
        .start_addr (slot_addr),
        .req_valid  (rd_req_valid),
        .req_ready  (rd_req_ready),
        .req_addr   (rd_req_addr),
        .rsp_valid  (rd_rsp_valid),
        .rsp_data   (rd_rsp_data),
        .busy       (fetch_busy),
        .rec_done   (rec_done),
        .rec        (rec)
    );

    rg_decide u_decide (
        .mode (dec_mode),
        .rec  (rec),
        .en   (dec_en)
    );

    // Remember which fetching mode is in progress
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_mode <= '0;
        end else if (take_mem) begin
            cur_mode <= slot_mode;
        end
    end

    // Result latch and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exec_en   <= 1'b1;
            eval_done <= 1'b0;
        end else begin
            eval_done <= take_const || rec_done;
            if (take_const || rec_done) exec_en <= dec_en;
        end
    end
endmodule

// File: rtl/render_gate_chk.sv
// Module: property checker for render_gate, attached by bind.
// Assumes reset is held for at least one clock edge at start-up.
module render_gate_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req_valid,
    input logic              rd_req_ready,
    input logic [ADDR_W-1:0] rd_req_addr,
    input logic              exec_en,
    input logic              busy,
    input logic              eval_done
);
    // R1: a reset cycle leaves the idle, enabled state behind it
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (exec_en && !busy && !eval_done && !rd_req_valid));

    // R7: an unaccepted request holds its address
    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

    // R8: reads only while busy
    a_r8_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> busy);

    // R10: the enable moves only with a completion pulse
    a_r10_en_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(exec_en) |-> eval_done);
endmodule

bind render_gate render_gate_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .exec_en      (exec_en),
    .busy         (busy),
    .eval_done    (eval_done)
);

// File: tb/render_gate_test.sv
`timescale 1ns/1ps
module render_gate_test;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_wr = 1'b0;
    logic [2:0]    mode_sel = '0;
    logic [AW-1:0] rec_base = '0;
    logic          rd_req_valid;
    logic          rd_req_ready = 1'b0;
    logic [AW-1:0] rd_req_addr;
    logic          rd_rsp_valid = 1'b0;
    logic [31:0]   rd_rsp_data = '0;
    logic          exec_en, busy, eval_done;

    int checks = 0;
    int fails = 0;
    int req_count = 0;
    int done_count = 0;
    int push_count = 0;
    int r10_bad = 0;
    int cycles = 0;

    bit          exp_q[$];
    string       tag_q[$];
    logic [31:0] addr_q[$];
    logic [31:0] mem[logic [31:0]];

    always #2 clk = ~clk;

    render_gate #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_sel(mode_sel),
        .rec_base(rec_base), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .exec_en(exec_en), .busy(busy), .eval_done(eval_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit model(input int m, input logic [31:0] s0, t0, s1, t1);
        case (m)
            0: return 1'b0;
            1: return 1'b1;
            2: return (s0 != 0) && (t0 != 0);
            3: return (s0 == s1) && (t0 == t1);
            4: return (s0 != s1) || (t0 != t1);
            default: return 1'b1;
        endcase
    endfunction

    // Driver: write a mode; for fetching modes load memory and expected addresses
    task automatic issue(input int m, input logic [31:0] base,
                         input logic [31:0] s0, t0, s1, t1,
                         input string tag, input bit expect_it);
        @(negedge clk);
        if (m >= 2 && m <= 4) begin
            mem[base] = s0; mem[base + 4] = t0; mem[base + 8] = s1; mem[base + 12] = t1;
            for (int k = 0; k < 4; k++) addr_q.push_back(base + 32'(4 * k));
        end
        if (expect_it) begin
            exp_q.push_back(model(m, s0, t0, s1, t1));
            tag_q.push_back(tag);
            push_count++;
        end
        mode_wr  = 1'b1;
        mode_sel = 3'(m);
        rec_base = base;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        while (exp_q.size() != 0 || busy) @(negedge clk);
        @(negedge clk);
        check("R8 busy low when idle", 32'(busy), 32'd0);
    endtask

    // Monitor: pop expected results on each completion pulse; track R10
    bit prev_en;
    bit prev_ok = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ok && exec_en != prev_en && !eval_done) r10_bad++;
            if (eval_done) begin
                done_count++;
                if (exp_q.size() == 0) begin
                    check("R9 unexpected evaluation", 32'd1, 32'd0);
                end else begin
                    bit    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, 32'(exec_en), 32'(e));
                end
            end
            prev_en = exec_en;
            prev_ok = 1'b1;
        end
    end

    // Memory model with varying accept and response delays
    initial begin
        int stall = 0;
        forever begin
            @(negedge clk);
            if (rst_n && rd_req_valid) begin
                logic [31:0] a;
                repeat (stall % 3) @(negedge clk);
                a = rd_req_addr;
                req_count++;
                check("R8 busy during read", 32'(busy), 32'd1);
                if (addr_q.size() == 0) check("R7 unexpected read", a, 32'hFFFF_FFFF);
                else check("R7 read address", a, addr_q.pop_front());
                rd_req_ready = 1'b1;
                @(negedge clk);
                rd_req_ready = 1'b0;
                repeat (stall % 4) @(negedge clk);
                rd_rsp_valid = 1'b1;
                rd_rsp_data  = mem.exists(a) ? mem[a] : 32'd0;
                @(negedge clk);
                rd_rsp_valid = 1'b0;
                stall++;
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int rc;
        repeat (2) @(negedge clk);
        check("R1 exec_en in reset", 32'(exec_en), 32'd1);
        check("R1 busy in reset", 32'(busy), 32'd0);
        check("R1 eval_done in reset", 32'(eval_done), 32'd0);
        check("R1 rd_req_valid in reset", 32'(rd_req_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 exec_en after reset", 32'(exec_en), 32'd1);

        // R2: constant modes, no memory traffic
        rc = req_count;
        issue(0, 0, 0, 0, 0, 0, "R2 forced off", 1'b1);
        wait_idle();
        issue(1, 0, 0, 0, 0, 0, "R2 forced on", 1'b1);
        wait_idle();
        check("R2 no reads", 32'(req_count), 32'(rc));

        // R3: nonzero test on the start words
        issue(2, 32'h0000_1000, 5, 7, 0, 0, "R3 both nonzero", 1'b1);      wait_idle();
        issue(2, 32'h0000_2000, 0, 7, 9, 9, "R3 zero sequence", 1'b1);     wait_idle();
        issue(2, 32'h0000_3000, 5, 0, 9, 9, "R3 zero tag", 1'b1);          wait_idle();

        // R4: equality
        issue(3, 32'h0000_4000, 11, 22, 11, 22, "R4 equal", 1'b1);         wait_idle();
        issue(3, 32'h0000_5000, 11, 22, 12, 22, "R4 seq differs", 1'b1);   wait_idle();
        issue(3, 32'h0000_6000, 11, 22, 11, 23, "R4 tag differs", 1'b1);   wait_idle();

        // R5: inequality, including a base that crosses a 16-byte boundary
        issue(4, 32'h0000_7FF8, 3, 4, 3, 4, "R5 equal", 1'b1);             wait_idle();
        issue(4, 32'hFFFF_0004, 3, 4, 8, 4, "R5 seq differs", 1'b1);       wait_idle();
        issue(4, 32'h0000_8000, 3, 4, 3, 9, "R5 tag differs", 1'b1);       wait_idle();

        // R6: undefined codes act as forced on, without reads
        for (int m = 5; m < 8; m++) begin
            issue(0, 0, 0, 0, 0, 0, "R2 forced off before R6", 1'b1);
            wait_idle();
            rc = req_count;
            issue(m, 32'h0000_9000, 0, 0, 0, 0, "R6 undefined code", 1'b1);
            wait_idle();
            check("R6 no reads", 32'(req_count), 32'(rc));
        end

        // R9: writes during a fetch; only the last one survives
        issue(0, 0, 0, 0, 0, 0, "R2 forced off before R9", 1'b1);
        wait_idle();
        issue(3, 32'h0000_A000, 1, 2, 1, 2, "R9 running fetch", 1'b1);
        repeat (2) @(negedge clk);
        check("R9 busy when held write arrives", 32'(busy), 32'd1);
        issue(0, 0, 0, 0, 0, 0, "R9 superseded", 1'b0);
        issue(1, 0, 0, 0, 0, 0, "R9 held write", 1'b1);
        check("R10 exec_en unchanged while fetching", 32'(exec_en), 32'd0);
        wait_idle();
        check("R9 final enable", 32'(exec_en), 32'd1);

        // R9: a held fetching write runs after the current one
        issue(4, 32'h0000_B000, 1, 1, 1, 1, "R9 first fetch", 1'b1);
        repeat (2) @(negedge clk);
        issue(2, 32'h0000_C000, 6, 6, 0, 0, "R9 held fetch", 1'b1);
        wait_idle();

        check("R9 evaluation count", 32'(done_count), 32'(push_count));
        check("R7 all expected reads seen", 32'(addr_q.size()), 32'd0);
        check("R10 enable moved only with done", 32'(r10_bad), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule